// File: doc/BRIEF.md
# Link and Activity LED Controller

This block drives three active-low indicator LEDs for a wireless network adapter: power, link and activity. A free-running prescaler divides the core clock into a square wave with 50% duty. Its default ratio gives a 10 Hz blink from a 44 MHz clock. Both blinking LEDs take their phase from this one prescaler, so they toggle in step.

Frame events from the transmit or receive path start or restart a hold window, and the activity LED blinks for as long as that window runs. The link LED stays lit while the link-up level is high. An association-success pulse or an ad-hoc beacon pulse opens a separate window, and inside it the link LED blinks instead of staying lit.

The prescaler and the link logic run whether or not main power is present, so the link LED keeps blinking in the deepest powered-down state. The activity LED only runs while main power is present. All LED outputs are registered.

Top module: `led_indicator_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, all three LED outputs are high (unlit).
- R2: `led_pwr_n` is low one cycle after `main_pwr` is sampled high, and high one cycle after it is sampled low.
- R3: The blink phase starts unlit after reset. It toggles every HALF_PERIOD clock cycles, giving a square wave with 50% duty.
- R4: After a one-cycle pulse on `tx_frame_p` or `rx_frame_p`, `led_act_n` is low when the blink phase is lit, for ACT_HOLD cycles. Outside that window it is high.
- R5: A new frame pulse that arrives while the activity window is running restarts the window at its full ACT_HOLD length.
- R6: While no link blink window is open, `led_link_n` equals the inverse of `link_up`, one cycle late.
- R7: A pulse on `assoc_ok_p` or `ibss_bcn_p` opens a window of LINK_HOLD cycles. Inside it, `led_link_n` follows the blink phase whatever the value of `link_up`. A new pulse restarts the window.
- R8: While `main_pwr` is low, `led_act_n` is high one cycle later and the activity window is cancelled. The link window and the blink prescaler keep running.
- R9: When the link window and the activity window are both open and main power is present, `led_link_n` and `led_act_n` are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| main_pwr | input | 1 | Main power present (the always-on logic ignores it) |
| link_up | input | 1 | Link established level |
| assoc_ok_p | input | 1 | One-cycle pulse on successful association |
| ibss_bcn_p | input | 1 | One-cycle pulse on a beacon received in an ad-hoc network |
| tx_frame_p | input | 1 | One-cycle pulse on a detected transmit frame |
| rx_frame_p | input | 1 | One-cycle pulse on a detected receive frame |
| led_pwr_n | output | 1 | Power LED, active low |
| led_link_n | output | 1 | Link LED, active low |
| led_act_n | output | 1 | Activity LED, active low |

## Verification
The hardest situation to reach is the one where both hold windows are open at once, main power then drops, and the link LED has to keep blinking in phase while the activity LED goes dark. The stimulus fires an association pulse and a frame pulse in the same cycle. It then lowers `main_pwr` partway through both windows and fires more link and frame pulses while power is off. This shows that frame events are ignored while power is off and that link events still restart their window. Retriggering is exercised by pulses spaced closer than the hold length, so that each window only ends after the last pulse.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef struct packed {
    logic pwr;
    logic link;
    logic act;
  } led_drive_t;

  localparam led_drive_t LED_ALL_OFF = '{pwr: 1'b1, link: 1'b1, act: 1'b1};
endpackage

// File: rtl/led_blink_prescaler.sv
module led_blink_prescaler #(
  parameter int unsigned HALF_PERIOD = 2200000
) (
  input  logic clk,
  input  logic rst,
  output logic blink_on
);
  localparam int unsigned CW = $clog2(HALF_PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      blink_on <= 1'b0;
    end else if (cnt == LAST) begin
      cnt      <= '0;
      blink_on <= ~blink_on;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> $stable(blink_on));
endmodule

// File: rtl/led_hold_timer.sv
module led_hold_timer #(
  parameter int unsigned HOLD = 4400000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trig,
  output logic active
);
  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic [HW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      remain <= '0;
    end else if (trig) begin
      remain <= HOLD_V;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (trig && !clr) |=> (remain == HOLD_V));
  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig && !clr && remain != '0) |=> (remain == $past(remain) - 1'b1));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !active);
endmodule

// File: rtl/led_indicator_ctrl.sv
module led_indicator_ctrl
  import led_pkg::*;
#(
  parameter int unsigned HALF_PERIOD = 2200000,
  parameter int unsigned ACT_HOLD    = 4400000,
  parameter int unsigned LINK_HOLD   = 4400000
) (
  input  logic clk,
  input  logic rst,
  input  logic main_pwr,
  input  logic link_up,
  input  logic assoc_ok_p,
  input  logic ibss_bcn_p,
  input  logic tx_frame_p,
  input  logic rx_frame_p,
  output logic led_pwr_n,
  output logic led_link_n,
  output logic led_act_n
);
  logic       blink_on;
  logic       act_active;
  logic       link_active;
  led_drive_t drive_q;

  led_blink_prescaler #(.HALF_PERIOD(HALF_PERIOD)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .blink_on (blink_on)
  );

  led_hold_timer #(.HOLD(ACT_HOLD)) u_act_hold (
    .clk    (clk),
    .rst    (rst),
    .clr    (~main_pwr),
    .trig   (tx_frame_p | rx_frame_p),
    .active (act_active)
  );

  // always-on domain: never cleared by loss of main power
  led_hold_timer #(.HOLD(LINK_HOLD)) u_link_hold (
    .clk    (clk),
    .rst    (rst),
    .clr    (1'b0),
    .trig   (assoc_ok_p | ibss_bcn_p),
    .active (link_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= LED_ALL_OFF;
    end else begin
      drive_q.pwr  <= ~main_pwr;
      drive_q.link <= ~(link_active ? blink_on : link_up);
      drive_q.act  <= ~(main_pwr & act_active & blink_on);
    end
  end

  assign led_pwr_n  = drive_q.pwr;
  assign led_link_n = drive_q.link;
  assign led_act_n  = drive_q.act;

  // R1
  reset_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (led_pwr_n && led_link_n && led_act_n));
  // R2
  pwr_on_chk: assert property (@(posedge clk) disable iff (rst)
    main_pwr |=> !led_pwr_n);
  // R8
  act_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !main_pwr |=> led_act_n);
  // R6
  link_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !link_active |=> (led_link_n == !$past(link_up)));
  // R9
  in_step_chk: assert property (@(posedge clk) disable iff (rst)
    (link_active && act_active && main_pwr) |=> (led_link_n == led_act_n));
endmodule

// File: tb/sim_led_indicator_ctrl.sv
module sim_led_indicator_ctrl;
  localparam int HALF = 3;
  localparam int AHOLD = 10;
  localparam int LHOLD = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_pwr = 1'b0, link_up = 1'b0;
  logic assoc_ok_p = 1'b0, ibss_bcn_p = 1'b0, tx_frame_p = 1'b0, rx_frame_p = 1'b0;
  logic led_pwr_n, led_link_n, led_act_n;

  int total = 0;
  int bad = 0;
  string phase_tag = "R1";

  // reference model state
  int n_edges = 0;
  int act_rem = 0;
  int link_rem = 0;
  logic exp_pwr = 1'b1, exp_link = 1'b1, exp_act = 1'b1;
  bit both_open = 0;

  always #5 clk = ~clk;

  led_indicator_ctrl #(.HALF_PERIOD(HALF), .ACT_HOLD(AHOLD), .LINK_HOLD(LHOLD)) u0 (
    .clk(clk), .rst(rst), .main_pwr(main_pwr), .link_up(link_up),
    .assoc_ok_p(assoc_ok_p), .ibss_bcn_p(ibss_bcn_p),
    .tx_frame_p(tx_frame_p), .rx_frame_p(rx_frame_p),
    .led_pwr_n(led_pwr_n), .led_link_n(led_link_n), .led_act_n(led_act_n)
  );

  // behavioural reference: phase from edges since reset (R3)
  always @(posedge clk) begin
    bit lit;
    if (rst) begin
      exp_pwr = 1'b1; exp_link = 1'b1; exp_act = 1'b1;
      n_edges = 0; act_rem = 0; link_rem = 0; both_open = 0;
    end else begin
      lit = ((n_edges / HALF) % 2) == 1;
      exp_pwr  = !main_pwr;
      exp_link = !((link_rem > 0) ? lit : link_up);
      exp_act  = !(main_pwr && act_rem > 0 && lit);
      both_open = (link_rem > 0) && (act_rem > 0) && main_pwr;
      if (!main_pwr) act_rem = 0;
      else if (tx_frame_p || rx_frame_p) act_rem = AHOLD;
      else if (act_rem > 0) act_rem = act_rem - 1;
      if (assoc_ok_p || ibss_bcn_p) link_rem = LHOLD;
      else if (link_rem > 0) link_rem = link_rem - 1;
      n_edges = n_edges + 1;
    end
  end

  task automatic check1(string req, logic act, logic expv, string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, expv, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    check1((phase_tag == "R1") ? "R1" : "R2", led_pwr_n, exp_pwr, "led_pwr_n");
    check1((phase_tag == "R1") ? "R1" : "R6/R7", led_link_n, exp_link, "led_link_n");
    check1((phase_tag == "R1") ? "R1" : "R4", led_act_n, exp_act, "led_act_n");
    // R9: shared phase when both windows open
    if (both_open) check1("R9", led_link_n, led_act_n, "link vs act");
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(4);
    rst = 1'b0;
    main_pwr = 1'b1;
    cyc(1);
    phase_tag = "R2";
    cyc(10);
    // R6: steady link
    phase_tag = "R6";
    link_up = 1'b1;
    cyc(12);
    // R4: single transmit event
    phase_tag = "R4";
    pulse(tx_frame_p);
    cyc(20);
    // R5: receive events closer than the hold window
    phase_tag = "R5";
    for (int k = 0; k < 4; k++) begin
      pulse(rx_frame_p);
      cyc(5);
    end
    cyc(15);
    // R7: association then ad-hoc beacon, link held up and down
    phase_tag = "R7";
    pulse(assoc_ok_p);
    cyc(8);
    link_up = 1'b0;
    pulse(ibss_bcn_p);
    cyc(20);
    // R9: both windows together
    phase_tag = "R9";
    link_up = 1'b1;
    assoc_ok_p = 1'b1; tx_frame_p = 1'b1;
    @(negedge clk);
    assoc_ok_p = 1'b0; tx_frame_p = 1'b0;
    cyc(5);
    // R8: power drops mid-window; frame pulses ignored, link keeps blinking
    phase_tag = "R8";
    main_pwr = 1'b0;
    cyc(3);
    pulse(rx_frame_p);
    pulse(assoc_ok_p);
    cyc(6);
    pulse(tx_frame_p);
    cyc(LHOLD + 4);
    main_pwr = 1'b1;
    cyc(6);
    // R3: long free-running stretch with link blinking
    phase_tag = "R3";
    pulse(ibss_bcn_p);
    cyc(40);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule